// File: doc/BRIEF.md
# JESD204B Transmit Link Sequencer

This block is the data-link-layer state machine for one transmit lane of a JESD204B link. It steps the lane through three phases. Code group synchronisation (CGS) sends K28.5 continuously. The initial lane alignment sequence (ILAS) sends a programmable number of multiframes, each framed by /R/ and /A/, with the configuration octets in the second one. User data then passes through, with optional end-of-frame and end-of-multiframe character replacement. The block drives one octet per clock together with a control-character flag. A later stage applies 8b/10b encoding and serialisation.

A multiframe is FRAME_OCTETS x MF_FRAMES octets. An internal position counter follows the local multiframe clock: `lmfc_tick` marks the final octet of each multiframe and realigns the counter. The state register has three named states: CGS (00), ILAS (01) and DATA (10). The transitions are:
- CGS_TO_ILAS: taken at the end of a tick cycle while `rcv_sync_n` is high, no reinit is pending, and either `sysref_hit` or `sysref_bypass` is set.
- ILAS_TO_DATA: taken at the end of the tick cycle that closes the final multiframe, unless the loop control is set.
- ILAS_TO_CGS and DATA_TO_CGS: taken on a pending reinit or on `rcv_sync_n` going low.

The configuration octets must fit inside the second multiframe, so CFG_OCTETS + 3 must not exceed the multiframe length.

Top module: `tl_link_seq`

## Requirements
- R1: After reset the state reads 00 (CGS). `tx_octet` is 0xBC with `tx_is_k`=1, and `ilas_mf` and `reinit_pend` both read 0.
- R2: In CGS every output octet is K28.5 (0xBC, `tx_is_k`=1).
- R3: CGS moves to ILAS only at the clock edge that ends a cycle with `lmfc_tick`=1, `rcv_sync_n`=1, no reinit pending, and `sysref_hit` or `sysref_bypass` set. The first ILAS octet is position 0 of a multiframe.
- R4: `ilas_len` holds the index of the last ILAS multiframe, which is the count minus 1. Values 0, 1 and 2 act as 3, so ILAS lasts max(`ilas_len`,3)+1 multiframes. ILAS moves to DATA at the end of the tick cycle of that last multiframe.
- R5: In every ILAS multiframe, position 0 carries 0x1C (K28.0) with k=1, and the final position carries 0x7C (K28.3) with k=1. Every other position not covered by R6 carries its position number as a data octet (k=0).
- R6: In ILAS multiframe index 1, position 1 carries 0x9C (K28.4) with k=1. Positions 2 to CFG_OCTETS+1 carry `ilas_cfg` octets as data, with bits [7:0] first.
- R7: While `ilas_loop`=1 the machine stays in ILAS and `ilas_mf` saturates at 255. Once the loop is cleared, it moves to DATA at the next tick.
- R8: In DATA, an octet that is not replaced is `tx_data` with k=0.
- R9: In DATA, with replacement enabled, a frame-final octet equal to the raw final octet of the previous DATA frame is replaced with k=1. It becomes 0x7C if it also ends the multiframe, and 0xFC (K28.7) otherwise. The first frame after entering DATA is never replaced.
- R10: With `repl_off`=1, DATA octets are always raw `tx_data` with k=0.
- R11: A `reinit_set` pulse makes `reinit_pend` read 1 in the next cycle. In the cycle after that the state is CGS and `reinit_pend` is 0. This holds from any state.
- R12: `rcv_sync_n` low during ILAS or DATA puts the state in CGS in the next cycle.
- R13: `link_state` uses the codes 00/01/10 and never 11. `ilas_mf` gives the current ILAS multiframe index and reads 0 in CGS.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Link clock, one octet per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| rcv_sync_n | input | 1 | Receiver synchronisation request, active low |
| lmfc_tick | input | 1 | Marks the final octet cycle of a multiframe |
| sysref_hit | input | 1 | A SYSREF rising edge has been sampled |
| sysref_bypass | input | 1 | Allow CGS exit without a SYSREF sample |
| ilas_len | input | 8 | ILAS multiframe count minus 1 |
| ilas_loop | input | 1 | Test mode: remain in ILAS |
| reinit_set | input | 1 | Write-one pulse requesting reinitialisation |
| repl_off | input | 1 | Disable data-phase character replacement |
| tx_data | input | 8 | User octet for the DATA phase |
| ilas_cfg | input | 8*CFG_OCTETS | Configuration octets for the second ILAS multiframe |
| tx_octet | output | 8 | Octet to the encoder |
| tx_is_k | output | 1 | Octet is a control character |
| link_state | output | 2 | Current state code |
| ilas_mf | output | 8 | Current ILAS multiframe index |
| reinit_pend | output | 1 | Self-clearing reinit control bit |

## Verification
The bench sweeps `ilas_len` across the clamp boundary (0 to 4, plus a larger value) and counts the exact ILAS length in octets. A design that omitted the clamp would leave ILAS after one to three multiframes, and an off-by-one would add or drop 32 octets. It holds SYSREF off across several ticks to catch a CGS exit that ignores the SYSREF gate. It runs the loop mode past 256 multiframes to catch an index that wraps instead of saturating. In the data phase it drives repeated frame-final octets, which exposes three faults: replacement in the first frame, /F/ where /A/ belongs, and replacement while disabled. Reinit and SYNC_N drops are checked cycle by cycle, so an extra or missing delay stage shows up at once.

// File: rtl/tlseq_pkg.sv
package tlseq_pkg;

    typedef enum logic [1:0] {
        ST_CGS  = 2'b00,
        ST_ILAS = 2'b01,
        ST_DATA = 2'b10
    } lstate_e;

    // Control character codes (unencoded octet values)
    localparam logic [7:0] K_SYNC    = 8'hBC;  // K28.5
    localparam logic [7:0] K_MFSTART = 8'h1C;  // K28.0 /R/
    localparam logic [7:0] K_MFEND   = 8'h7C;  // K28.3 /A/
    localparam logic [7:0] K_CFGMARK = 8'h9C;  // K28.4 /Q/
    localparam logic [7:0] K_FREND   = 8'hFC;  // K28.7 /F/

    // Lowest legal index of the last ILAS multiframe (four multiframes)
    localparam int ILAS_MIN_LAST = 3;

    // Position of the configuration marker inside multiframe index 1
    localparam int CFG_MARK_POS = 1;

endpackage

// File: rtl/tlseq_mf_pos.sv
module tlseq_mf_pos #(
    parameter int FRAME_OCTETS = 2,
    parameter int MF_FRAMES    = 16,
    parameter int PW           = $clog2(FRAME_OCTETS * MF_FRAMES)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          lmfc_tick,
    output logic [PW-1:0] pos,
    output logic          frame_end,
    output logic          mf_end
);
    localparam int MF = FRAME_OCTETS * MF_FRAMES;
    localparam int FW = (FRAME_OCTETS > 1) ? $clog2(FRAME_OCTETS) : 1;

    logic [PW-1:0] pos_q;
    logic [FW-1:0] fpos_q;

    assign pos       = pos_q;
    assign mf_end    = (pos_q == PW'(MF - 1));
    assign frame_end = (fpos_q == FW'(FRAME_OCTETS - 1));

    // The tick marks the final octet of a multiframe; it realigns both counters.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pos_q  <= '0;
            fpos_q <= '0;
        end else if (lmfc_tick || mf_end) begin
            pos_q  <= '0;
            fpos_q <= '0;
        end else begin
            pos_q  <= pos_q + PW'(1);
            fpos_q <= frame_end ? '0 : fpos_q + FW'(1);
        end
    end

endmodule

// File: rtl/tlseq_fsm.sv
module tlseq_fsm
    import tlseq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rcv_sync_n,
    input  logic       lmfc_tick,
    input  logic       sysref_hit,
    input  logic       sysref_bypass,
    input  logic [7:0] ilas_len,
    input  logic       ilas_loop,
    input  logic       reinit_set,
    output lstate_e    state,
    output logic [7:0] mf_idx,
    output logic       reinit_pend
);
    lstate_e    st_q, st_d;
    logic [7:0] idx_q, idx_d;
    logic [7:0] last_idx;
    logic       pend_q;
    logic       exit_cgs, abort, ilas_done;

    // R4: short programmed lengths behave as four multiframes
    assign last_idx  = (ilas_len < 8'(ILAS_MIN_LAST)) ? 8'(ILAS_MIN_LAST) : ilas_len;
    // R11, R12: reinit request or receiver sync loss returns to CGS
    assign abort     = pend_q || !rcv_sync_n;
    // R3: CGS exit gated on sync, SYSREF sample (or bypass) and the tick
    assign exit_cgs  = !pend_q && rcv_sync_n && (sysref_hit || sysref_bypass) && lmfc_tick;
    // R4, R7: leave ILAS on the tick closing the last multiframe unless looping
    assign ilas_done = lmfc_tick && !ilas_loop && (idx_q >= last_idx);

    always_comb begin
        st_d  = st_q;
        idx_d = idx_q;
        unique case (st_q)
            ST_CGS: begin
                idx_d = '0;
                if (exit_cgs) begin
                    st_d = ST_ILAS;
                end
            end
            ST_ILAS: begin
                if (abort) begin
                    st_d  = ST_CGS;
                    idx_d = '0;
                end else if (ilas_done) begin
                    st_d = ST_DATA;
                end else if (lmfc_tick && (idx_q != 8'hFF)) begin
                    idx_d = idx_q + 8'd1;
                end
            end
            ST_DATA: begin
                if (abort) begin
                    st_d  = ST_CGS;
                    idx_d = '0;
                end
            end
            default: begin
                st_d  = ST_CGS;
                idx_d = '0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q   <= ST_CGS;
            idx_q  <= '0;
            pend_q <= 1'b0;
        end else begin
            st_q   <= st_d;
            idx_q  <= idx_d;
            // R11: the bit lives for one cycle and clears as CGS is entered
            pend_q <= reinit_set;
        end
    end

    assign state       = st_q;
    assign mf_idx      = idx_q;
    assign reinit_pend = pend_q;

endmodule

// File: rtl/tlseq_octet.sv
module tlseq_octet
    import tlseq_pkg::*;
#(
    parameter int PW         = 5,
    parameter int CFG_OCTETS = 14
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  lstate_e                 state,
    input  logic [7:0]              mf_idx,
    input  logic [PW-1:0]           pos,
    input  logic                    frame_end,
    input  logic                    mf_end,
    input  logic [7:0]              tx_data,
    input  logic [8*CFG_OCTETS-1:0] ilas_cfg,
    input  logic                    repl_off,
    output logic [7:0]              tx_octet,
    output logic                    tx_is_k
);
    localparam int CW = (CFG_OCTETS > 1) ? $clog2(CFG_OCTETS) : 1;
    localparam int CFG_FIRST = CFG_MARK_POS + 1;

    logic [7:0]    cfg_arr [CFG_OCTETS];
    logic [7:0]    prev_q;
    logic          prev_vld_q;
    logic          cfg_mf, cfg_mark, in_cfg, repl_hit;
    logic [CW-1:0] cfg_sel;

    for (genvar g = 0; g < CFG_OCTETS; g++) begin : g_cfg
        assign cfg_arr[g] = ilas_cfg[8*g +: 8];
    end

    assign cfg_mf   = (mf_idx == 8'd1);
    assign cfg_mark = cfg_mf && (int'(pos) == CFG_MARK_POS);
    assign in_cfg   = cfg_mf && (int'(pos) >= CFG_FIRST) && (int'(pos) < CFG_FIRST + CFG_OCTETS);
    assign cfg_sel  = CW'(int'(pos) - CFG_FIRST);
    // R9: repeat of the previous raw frame-final octet, never in the first frame
    assign repl_hit = !repl_off && frame_end && prev_vld_q && (tx_data == prev_q);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q     <= '0;
            prev_vld_q <= 1'b0;
        end else if (state != ST_DATA) begin
            prev_vld_q <= 1'b0;
        end else if (frame_end) begin
            prev_q     <= tx_data;
            prev_vld_q <= 1'b1;
        end
    end

    always_comb begin
        tx_octet = K_SYNC;
        tx_is_k  = 1'b1;
        unique case (state)
            ST_CGS: begin
                tx_octet = K_SYNC;           // R2
                tx_is_k  = 1'b1;
            end
            ST_ILAS: begin
                if (pos == '0) begin         // R5
                    tx_octet = K_MFSTART;
                    tx_is_k  = 1'b1;
                end else if (mf_end) begin
                    tx_octet = K_MFEND;
                    tx_is_k  = 1'b1;
                end else if (cfg_mark) begin // R6
                    tx_octet = K_CFGMARK;
                    tx_is_k  = 1'b1;
                end else if (in_cfg) begin
                    tx_octet = cfg_arr[cfg_sel];
                    tx_is_k  = 1'b0;
                end else begin
                    tx_octet = 8'(pos);
                    tx_is_k  = 1'b0;
                end
            end
            ST_DATA: begin
                if (repl_hit) begin          // R9
                    tx_octet = mf_end ? K_MFEND : K_FREND;
                    tx_is_k  = 1'b1;
                end else begin               // R8, R10
                    tx_octet = tx_data;
                    tx_is_k  = 1'b0;
                end
            end
            default: begin
                tx_octet = K_SYNC;
                tx_is_k  = 1'b1;
            end
        endcase
    end

endmodule

// File: rtl/tl_link_seq.sv
module tl_link_seq
    import tlseq_pkg::*;
#(
    parameter int FRAME_OCTETS = 2,
    parameter int MF_FRAMES    = 16,
    parameter int CFG_OCTETS   = 14
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    rcv_sync_n,
    input  logic                    lmfc_tick,
    input  logic                    sysref_hit,
    input  logic                    sysref_bypass,
    input  logic [7:0]              ilas_len,
    input  logic                    ilas_loop,
    input  logic                    reinit_set,
    input  logic                    repl_off,
    input  logic [7:0]              tx_data,
    input  logic [8*CFG_OCTETS-1:0] ilas_cfg,
    output logic [7:0]              tx_octet,
    output logic                    tx_is_k,
    output logic [1:0]              link_state,
    output logic [7:0]              ilas_mf,
    output logic                    reinit_pend
);
    localparam int MF = FRAME_OCTETS * MF_FRAMES;
    localparam int PW = $clog2(MF);

    lstate_e       state;
    logic [7:0]    mf_idx;
    logic [PW-1:0] pos;
    logic          frame_end, mf_end;

    tlseq_mf_pos #(
        .FRAME_OCTETS(FRAME_OCTETS),
        .MF_FRAMES   (MF_FRAMES),
        .PW          (PW)
    ) u_pos (
        .clk      (clk),
        .rst_n    (rst_n),
        .lmfc_tick(lmfc_tick),
        .pos      (pos),
        .frame_end(frame_end),
        .mf_end   (mf_end)
    );

    tlseq_fsm u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .rcv_sync_n   (rcv_sync_n),
        .lmfc_tick    (lmfc_tick),
        .sysref_hit   (sysref_hit),
        .sysref_bypass(sysref_bypass),
        .ilas_len     (ilas_len),
        .ilas_loop    (ilas_loop),
        .reinit_set   (reinit_set),
        .state        (state),
        .mf_idx       (mf_idx),
        .reinit_pend  (reinit_pend)
    );

    tlseq_octet #(
        .PW        (PW),
        .CFG_OCTETS(CFG_OCTETS)
    ) u_oct (
        .clk      (clk),
        .rst_n    (rst_n),
        .state    (state),
        .mf_idx   (mf_idx),
        .pos      (pos),
        .frame_end(frame_end),
        .mf_end   (mf_end),
        .tx_data  (tx_data),
        .ilas_cfg (ilas_cfg),
        .repl_off (repl_off),
        .tx_octet (tx_octet),
        .tx_is_k  (tx_is_k)
    );

    // R13: status view
    assign link_state = state;
    assign ilas_mf    = mf_idx;

endmodule

// File: rtl/tl_link_seq_chk.sv
module tl_link_seq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       rcv_sync_n,
    input logic       lmfc_tick,
    input logic       sysref_hit,
    input logic       sysref_bypass,
    input logic       ilas_loop,
    input logic       reinit_set,
    input logic [7:0] tx_data,
    input logic [7:0] tx_octet,
    input logic       tx_is_k,
    input logic [1:0] link_state,
    input logic [7:0] ilas_mf,
    input logic       reinit_pend
);

    a_r2_cgs_comma: assert property (@(posedge clk) disable iff (!rst_n)
        (link_state == 2'b00) |-> (tx_is_k && (tx_octet == 8'hBC)));

    a_r3_gated_exit: assert property (@(posedge clk) disable iff (!rst_n)
        ((link_state == 2'b00) && !(lmfc_tick && rcv_sync_n && (sysref_hit || sysref_bypass)))
        |=> (link_state != 2'b01));

    a_r4_min_length: assert property (@(posedge clk) disable iff (!rst_n)
        ((link_state == 2'b10) && ($past(link_state) == 2'b01)) |-> ($past(ilas_mf) >= 8'd3));

    a_r7_loop_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (ilas_loop && (link_state == 2'b01) && !reinit_pend && rcv_sync_n) |=> (link_state == 2'b01));

    a_r8_data_pass: assert property (@(posedge clk) disable iff (!rst_n)
        ((link_state == 2'b10) && !tx_is_k) |-> (tx_octet == tx_data));

    a_r11_pend_set: assert property (@(posedge clk) disable iff (!rst_n)
        reinit_set |=> reinit_pend);

    a_r11_pend_cgs: assert property (@(posedge clk) disable iff (!rst_n)
        reinit_pend |=> (link_state == 2'b00));

    a_r12_sync_loss: assert property (@(posedge clk) disable iff (!rst_n)
        ((link_state != 2'b00) && !rcv_sync_n) |=> (link_state == 2'b00));

    a_r13_legal_code: assert property (@(posedge clk) disable iff (!rst_n)
        link_state != 2'b11);

    a_r13_idx_cgs: assert property (@(posedge clk) disable iff (!rst_n)
        (link_state == 2'b00) |-> (ilas_mf == 8'd0));

endmodule

bind tl_link_seq tl_link_seq_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .rcv_sync_n   (rcv_sync_n),
    .lmfc_tick    (lmfc_tick),
    .sysref_hit   (sysref_hit),
    .sysref_bypass(sysref_bypass),
    .ilas_loop    (ilas_loop),
    .reinit_set   (reinit_set),
    .tx_data      (tx_data),
    .tx_octet     (tx_octet),
    .tx_is_k      (tx_is_k),
    .link_state   (link_state),
    .ilas_mf      (ilas_mf),
    .reinit_pend  (reinit_pend)
);

// File: tb/tl_link_seq_test.sv
`timescale 1ns/1ps
module tl_link_seq_test;
    localparam int F  = 2;
    localparam int K  = 16;
    localparam int MF = F * K;
    localparam int CN = 14;

    // {ilas_len, expected multiframe count}
    localparam logic [16:0] ILAS_VEC [6] = '{
        {8'd0, 9'd4}, {8'd1, 9'd4}, {8'd2, 9'd4},
        {8'd3, 9'd4}, {8'd4, 9'd5}, {8'd9, 9'd10}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          rcv_sync_n = 1'b1;
    logic          lmfc_tick = 1'b0;
    logic          sysref_hit = 1'b1;
    logic          sysref_bypass = 1'b0;
    logic [7:0]    ilas_len = 8'd0;
    logic          ilas_loop = 1'b0;
    logic          reinit_set = 1'b0;
    logic          repl_off = 1'b0;
    logic [7:0]    tx_data = 8'd0;
    logic [8*CN-1:0] ilas_cfg = '0;
    logic [7:0]    tx_octet;
    logic          tx_is_k;
    logic [1:0]    link_state;
    logic [7:0]    ilas_mf;
    logic          reinit_pend;

    int errors = 0;
    int checks = 0;
    int bpos = 0;

    always #10 clk = ~clk;

    tl_link_seq #(.FRAME_OCTETS(F), .MF_FRAMES(K), .CFG_OCTETS(CN)) uut (
        .clk(clk), .rst_n(rst_n), .rcv_sync_n(rcv_sync_n), .lmfc_tick(lmfc_tick),
        .sysref_hit(sysref_hit), .sysref_bypass(sysref_bypass), .ilas_len(ilas_len),
        .ilas_loop(ilas_loop), .reinit_set(reinit_set), .repl_off(repl_off),
        .tx_data(tx_data), .ilas_cfg(ilas_cfg), .tx_octet(tx_octet), .tx_is_k(tx_is_k),
        .link_state(link_state), .ilas_mf(ilas_mf), .reinit_pend(reinit_pend)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    // Advance one cycle; the tick marks the final octet of a multiframe
    task automatic next();
        @(posedge clk);
        #1;
        bpos = (bpos + 1) % MF;
        @(negedge clk);
        lmfc_tick = (bpos == MF - 1);
        #1;
    endtask

    task automatic do_reset();
        rcv_sync_n = 1'b1; sysref_hit = 1'b1; sysref_bypass = 1'b0;
        ilas_len = 8'd0; ilas_loop = 1'b0; reinit_set = 1'b0;
        repl_off = 1'b0; tx_data = 8'd0; lmfc_tick = 1'b0;
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        bpos = 0;
        #1;
    endtask

    task automatic goto_ilas();
        while (bpos != MF - 1) next();
        check("R3 still CGS in tick cycle", link_state, 2'b00);
        next();
        check("R3 ILAS after tick", link_state, 2'b01);
        check("R3 ILAS starts at position 0", {tx_is_k, tx_octet}, {1'b1, 8'h1C});
    endtask

    function automatic logic [8:0] exp_ilas(input int m, input int p);
        if (p == 0) return {1'b1, 8'h1C};
        if (p == MF - 1) return {1'b1, 8'h7C};
        if (m == 1 && p == 1) return {1'b1, 8'h9C};
        if (m == 1 && p >= 2 && p < CN + 2) return {1'b0, 8'hC0 + 8'(p - 2)};
        return {1'b0, 8'(p)};
    endfunction

    task automatic run_ilas(output int n);
        n = 0;
        while (link_state == 2'b01 && n < 20000) begin
            if ((n / MF) == 1) check("R6 ilas octet", {tx_is_k, tx_octet}, exp_ilas(n / MF, bpos));
            else check("R5 ilas octet", {tx_is_k, tx_octet}, exp_ilas(n / MF, bpos));
            check("R13 ilas index", ilas_mf, n / MF);
            n++;
            next();
        end
    endtask

    initial begin
        #4_000_000;
        errors++;
        $display("FAIL watchdog expired actual=running expected=finished");
        summary();
        $finish;
    end

    initial begin
        int n;
        logic [7:0] prev;
        logic       pv;
        logic [8:0] exp;
        for (int i = 0; i < CN; i++) ilas_cfg[8*i +: 8] = 8'hC0 + 8'(i);

        // R1: reset state
        do_reset();
        check("R1 reset state", link_state, 2'b00);
        check("R1 reset octet", {tx_is_k, tx_octet}, {1'b1, 8'hBC});
        check("R1 reset index", ilas_mf, 0);
        check("R1 reset pend", reinit_pend, 0);

        // R2: CGS with the receiver holding sync low, through two ticks
        rcv_sync_n = 1'b0;
        for (int i = 0; i < 70; i++) begin
            check("R2 K28.5 in CGS", {tx_is_k, tx_octet}, {1'b1, 8'hBC});
            next();
        end
        check("R3 sync low keeps CGS", link_state, 2'b00);

        // R3: no SYSREF sample and no bypass keeps CGS; bypass releases it
        do_reset();
        sysref_hit = 1'b0;
        repeat (70) next();
        check("R3 no SYSREF keeps CGS", link_state, 2'b00);
        sysref_bypass = 1'b1;
        goto_ilas();

        // R4/R5/R6: table of ILAS lengths
        for (int v = 0; v < 6; v++) begin
            do_reset();
            ilas_len = ILAS_VEC[v][16:9];
            goto_ilas();
            run_ilas(n);
            check("R4 ilas octet count", n, MF * int'(ILAS_VEC[v][8:0]));
            check("R4 data after ilas", link_state, 2'b10);
        end

        // R7: loop mode stays and saturates
        do_reset();
        ilas_loop = 1'b1;
        goto_ilas();
        repeat (8 * MF) next();
        check("R7 loop index after 8", ilas_mf, 8);
        repeat (252 * MF) next();
        check("R7 loop still ILAS", link_state, 2'b01);
        check("R7 loop index saturates", ilas_mf, 255);
        ilas_loop = 1'b0;
        while (bpos != MF - 1) next();
        check("R7 ILAS until tick", link_state, 2'b01);
        next();
        check("R7 DATA after loop cleared", link_state, 2'b10);

        // R8/R9/R10: data phase replacement
        do_reset();
        goto_ilas();
        run_ilas(n);
        check("R4 data reached", link_state, 2'b10);
        pv = 1'b0; prev = 8'd0;
        for (int i = 0; i < 96; i++) begin
            repl_off = (i >= 64);
            tx_data = (bpos % 2 == 1) ? 8'h40 + 8'(i / 4) : 8'h10 + 8'(bpos);
            #1;
            exp = {1'b0, tx_data};
            if (bpos % 2 == 1) begin
                if (pv && tx_data == prev && !repl_off)
                    exp = {1'b1, (bpos == MF - 1) ? 8'h7C : 8'hFC};
                prev = tx_data;
                pv = 1'b1;
            end
            if (exp[8]) check("R9 replaced octet", {tx_is_k, tx_octet}, exp);
            else if (repl_off) check("R10 raw octet", {tx_is_k, tx_octet}, exp);
            else check("R8 passthrough octet", {tx_is_k, tx_octet}, exp);
            next();
        end
        repl_off = 1'b0;

        // R12: sync loss in DATA
        rcv_sync_n = 1'b0;
        #1;
        check("R12 still DATA same cycle", link_state, 2'b10);
        next();
        check("R12 CGS after sync loss in DATA", link_state, 2'b00);
        rcv_sync_n = 1'b1;

        // R12: sync loss in ILAS
        goto_ilas();
        next();
        rcv_sync_n = 1'b0;
        next();
        check("R12 CGS after sync loss in ILAS", link_state, 2'b00);
        rcv_sync_n = 1'b1;

        // R11: reinit from ILAS
        goto_ilas();
        next();
        reinit_set = 1'b1;
        next();
        reinit_set = 1'b0;
        #1;
        check("R11 pend reads 1", reinit_pend, 1);
        check("R11 state held during pend", link_state, 2'b01);
        next();
        check("R11 CGS after pend", link_state, 2'b00);
        check("R11 pend self clears", reinit_pend, 0);
        check("R11 K28.5 after reinit", {tx_is_k, tx_octet}, {1'b1, 8'hBC});

        // R11: reinit while in CGS
        reinit_set = 1'b1;
        next();
        reinit_set = 1'b0;
        #1;
        check("R11 pend in CGS", reinit_pend, 1);
        next();
        check("R11 pend clears in CGS", reinit_pend, 0);
        check("R11 stays CGS", link_state, 2'b00);

        summary();
        $finish;
    end

endmodule